// File: doc/BRIEF.md
# Port and Block I/O Transfer Sequencer

This block carries out the port transfers of a small 8-bit processor once the instruction has been decoded. A one-cycle start pulse brings in a command code, the accumulator, the B and C registers, an immediate port byte and a 16-bit memory pointer HL. The sequencer then drives a port bus and a memory bus. The two buses are separate address spaces with their own request strobes. It also updates B and HL as the transfer runs. When it finishes it pulses done and reports whether B ended at zero.

The port address is always 16 bits wide. The low byte is the port number, taken from the immediate byte or from C. The high byte comes from the accumulator, from the port number itself, or from the B count. In block transfers B is both the byte counter and the upper port address, so the address changes with every byte. A starting count of zero means 256 bytes.

Top module: `blkio_sequencer`

## Requirements
- R1: Command 0 reads the port at {accumulator, immediate port} and loads the byte into acc_out. Command 1 writes the accumulator to that address.
- R2: When the compat input is high at start, commands 0 and 1 place the immediate port number in address bits 15:8 as well as in bits 7:0.
- R3: Command 2 (read into acc_out) and command 3 (write the accumulator) address the port at {B, C} and leave B and HL unchanged.
- R4: A block input reads the port at {B, C} using B before its decrement. It then writes that byte to memory at HL and decrements B.
- R5: A block output decrements B first. It then reads memory at HL and writes that byte to the port at {new B, C}.
- R6: Up-stepping block commands add one to HL after each byte and down-stepping ones subtract one, both wrapping modulo 65536.
- R7: Single-step block commands move exactly one byte: 4 in/up, 5 in/down, 6 out/up, 7 out/down.
- R8: Repeating block commands keep moving bytes until B reaches zero, and a starting B of zero gives 256 bytes: 8 in/up, 9 in/down, 10 out/up, 11 out/down.
- R9: A request holds, with its address, direction and data stable, until its ready input is seen. Port and memory requests are never active together.
- R10: done is high for exactly one cycle at the end of a command, with zero equal to (b_out == 0), and busy drops on the next cycle.
- R11: Command codes 12 to 15 finish with done and make no bus access, leaving B, HL and the accumulator at their loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd | input | 4 | Command code |
| compat | input | 1 | Immediate-port high byte copies the port number |
| acc_in | input | DATA_W | Starting accumulator |
| b_in | input | DATA_W | Starting B count / upper port byte |
| c_in | input | DATA_W | Port number for register and block forms |
| port_in | input | DATA_W | Immediate port number |
| hl_in | input | HL_W | Starting memory pointer |
| io_req | output | 1 | Port access request |
| io_we | output | 1 | Port access is a write |
| io_addr | output | 2*DATA_W | Port address |
| io_wdata | output | DATA_W | Port write data |
| io_rdata | input | DATA_W | Port read data |
| io_rdy | input | 1 | Port access completes this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | HL_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_rdy | input | 1 | Memory access completes this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| zero | output | 1 | B is zero |
| acc_out | output | DATA_W | Accumulator after the command |
| b_out | output | DATA_W | B after the command |
| hl_out | output | HL_W | HL after the command |

## Verification
The bench builds the block with its defaults: 8-bit data, a 16-bit pointer and the compat option enabled. With these values a full 256-byte repeat from a zero count fits in a short run, and HL can be stepped across both wrap points (FFFF to 0000 and back). The enabled option also puts the port-number copy into the upper address byte within reach. The bus models answer with random ready delays. The bench compares the full sequence of port and memory accesses for each command, including every upper address byte, against the list it computes on its own.

// File: rtl/blkio_pkg.sv
package blkio_pkg;

   localparam int CMD_W      = 4;
   localparam int NUM_CMDS   = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IO,
      ST_MEM,
      ST_STEP,
      ST_FIN
   } state_e;

   // Decoded command attributes
   typedef struct packed {
      logic is_out;     // data flows towards the port
      logic is_imm;     // immediate-port form
      logic is_block;   // uses memory and the B count
      logic repeat_en;  // continue until B reaches zero
      logic step_down;  // HL moves downward
   } kind_t;

   function automatic logic cmd_known(input logic [CMD_W-1:0] code);
      return code < CMD_W'(NUM_CMDS);
   endfunction

   function automatic kind_t cmd_decode(input logic [CMD_W-1:0] code);
      kind_t k;
      k.is_imm    = (code < CMD_W'(2));
      k.is_block  = (code >= CMD_W'(4)) && cmd_known(code);
      k.is_out    = k.is_block ? code[1] : code[0];
      k.repeat_en = (code >= CMD_W'(8)) && cmd_known(code);
      k.step_down = k.is_block & code[0];
      return k;
   endfunction

endpackage

// File: rtl/blkio_addr.sv
module blkio_addr #(
   parameter int DATA_W = 8
) (
   input  logic                  sel_imm,
   input  logic                  hi_from_port,
   input  logic [DATA_W-1:0]     port_num,
   input  logic [DATA_W-1:0]     acc,
   input  logic [DATA_W-1:0]     cnt_b,
   input  logic [DATA_W-1:0]     reg_c,
   output logic [2*DATA_W-1:0]   addr
);

   logic [DATA_W-1:0] imm_hi;

   always_comb begin
      imm_hi = hi_from_port ? port_num : acc;
      if (sel_imm)
         addr = {imm_hi, port_num};
      else
         addr = {cnt_b, reg_c};
   end

endmodule

// File: rtl/blkio_step.sv
module blkio_step #(
   parameter int DATA_W = 8,
   parameter int HL_W   = 16
) (
   input  logic [DATA_W-1:0] b_cur,
   input  logic [HL_W-1:0]   hl_cur,
   input  logic              step_down,
   input  logic              dec_b,
   output logic [DATA_W-1:0] b_after,
   output logic [HL_W-1:0]   hl_after
);

   localparam logic [DATA_W-1:0] B_ONE  = DATA_W'(1);
   localparam logic [HL_W-1:0]   HL_ONE = HL_W'(1);

   always_comb begin
      hl_after = step_down ? (hl_cur - HL_ONE) : (hl_cur + HL_ONE);
      b_after  = dec_b ? (b_cur - B_ONE) : b_cur;
   end

endmodule

// File: rtl/blkio_ctrl.sv
module blkio_ctrl
   import blkio_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HL_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CMD_W-1:0]   cmd,
   input  logic               compat_eff,
   input  logic [DATA_W-1:0]  acc_in,
   input  logic [DATA_W-1:0]  b_in,
   input  logic [DATA_W-1:0]  c_in,
   input  logic [DATA_W-1:0]  port_in,
   input  logic [HL_W-1:0]    hl_in,
   input  logic [DATA_W-1:0]  io_rdata,
   input  logic               io_rdy,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               mem_rdy,
   input  logic [DATA_W-1:0]  b_after,
   input  logic [HL_W-1:0]    hl_after,
   output state_e             state,
   output kind_t              kind,
   output logic               compat_q,
   output logic [DATA_W-1:0]  acc_q,
   output logic [DATA_W-1:0]  b_q,
   output logic [DATA_W-1:0]  c_q,
   output logic [DATA_W-1:0]  port_q,
   output logic [HL_W-1:0]    hl_q,
   output logic [DATA_W-1:0]  data_q
);

   localparam logic [DATA_W-1:0] B_ONE = DATA_W'(1);

   kind_t       kind_new;
   logic        known_new;
   logic        more;

   always_comb begin
      kind_new  = cmd_decode(cmd);
      known_new = cmd_known(cmd);
      more      = kind.repeat_en && (b_after != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         kind     <= '0;
         compat_q <= 1'b0;
         acc_q    <= '0;
         b_q      <= '0;
         c_q      <= '0;
         port_q   <= '0;
         hl_q     <= '0;
         data_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  kind     <= kind_new;
                  compat_q <= compat_eff;
                  acc_q    <= acc_in;
                  c_q      <= c_in;
                  port_q   <= port_in;
                  hl_q     <= hl_in;
                  // output blocks decrement the count before the first byte
                  b_q      <= (kind_new.is_block && kind_new.is_out) ? (b_in - B_ONE) : b_in;
                  if (!known_new)
                     state <= ST_FIN;
                  else if (kind_new.is_block && kind_new.is_out)
                     state <= ST_MEM;
                  else
                     state <= ST_IO;
               end
            end
            ST_IO: begin
               if (io_rdy) begin
                  if (!kind.is_out) begin
                     if (kind.is_block) data_q <= io_rdata;
                     else               acc_q  <= io_rdata;
                  end
                  if (!kind.is_block)   state <= ST_FIN;
                  else if (kind.is_out) state <= ST_STEP;
                  else                  state <= ST_MEM;
               end
            end
            ST_MEM: begin
               if (mem_rdy) begin
                  if (kind.is_out) begin
                     data_q <= mem_rdata;
                     state  <= ST_IO;
                  end else begin
                     state  <= ST_STEP;
                  end
               end
            end
            ST_STEP: begin
               hl_q <= hl_after;
               if (more) begin
                  b_q   <= kind.is_out ? (b_after - B_ONE) : b_after;
                  state <= kind.is_out ? ST_MEM : ST_IO;
               end else begin
                  b_q   <= b_after;
                  state <= ST_FIN;
               end
            end
            ST_FIN: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/blkio_sequencer.sv
module blkio_sequencer
   import blkio_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int HL_W      = 16,
   parameter bit COMPAT_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [CMD_W-1:0]     cmd,
   input  logic                 compat,
   input  logic [DATA_W-1:0]    acc_in,
   input  logic [DATA_W-1:0]    b_in,
   input  logic [DATA_W-1:0]    c_in,
   input  logic [DATA_W-1:0]    port_in,
   input  logic [HL_W-1:0]      hl_in,
   output logic                 io_req,
   output logic                 io_we,
   output logic [2*DATA_W-1:0]  io_addr,
   output logic [DATA_W-1:0]    io_wdata,
   input  logic [DATA_W-1:0]    io_rdata,
   input  logic                 io_rdy,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [HL_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata,
   input  logic                 mem_rdy,
   output logic                 busy,
   output logic                 done,
   output logic                 zero,
   output logic [DATA_W-1:0]    acc_out,
   output logic [DATA_W-1:0]    b_out,
   output logic [HL_W-1:0]      hl_out
);

   localparam int IO_AW = 2 * DATA_W;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("blkio_sequencer: DATA_W must be at least 2");
   end
   if (HL_W < 2) begin : g_bad_hl_w
      $error("blkio_sequencer: HL_W must be at least 2");
   end

   logic compat_eff;

   if (COMPAT_EN) begin : g_compat
      assign compat_eff = compat;
   end else begin : g_no_compat
      assign compat_eff = 1'b0 & compat;
   end

   state_e              state;
   kind_t               kind;
   logic                compat_q;
   logic [DATA_W-1:0]   acc_q, b_q, c_q, port_q, data_q;
   logic [HL_W-1:0]     hl_q;
   logic [DATA_W-1:0]   b_after;
   logic [HL_W-1:0]     hl_after;
   logic [IO_AW-1:0]    addr_w;

   blkio_ctrl #(.DATA_W(DATA_W), .HL_W(HL_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cmd        (cmd),
      .compat_eff (compat_eff),
      .acc_in     (acc_in),
      .b_in       (b_in),
      .c_in       (c_in),
      .port_in    (port_in),
      .hl_in      (hl_in),
      .io_rdata   (io_rdata),
      .io_rdy     (io_rdy),
      .mem_rdata  (mem_rdata),
      .mem_rdy    (mem_rdy),
      .b_after    (b_after),
      .hl_after   (hl_after),
      .state      (state),
      .kind       (kind),
      .compat_q   (compat_q),
      .acc_q      (acc_q),
      .b_q        (b_q),
      .c_q        (c_q),
      .port_q     (port_q),
      .hl_q       (hl_q),
      .data_q     (data_q)
   );

   blkio_addr #(.DATA_W(DATA_W)) u_addr (
      .sel_imm      (kind.is_imm),
      .hi_from_port (compat_q),
      .port_num     (port_q),
      .acc          (acc_q),
      .cnt_b        (b_q),
      .reg_c        (c_q),
      .addr         (addr_w)
   );

   blkio_step #(.DATA_W(DATA_W), .HL_W(HL_W)) u_step (
      .b_cur     (b_q),
      .hl_cur    (hl_q),
      .step_down (kind.step_down),
      .dec_b     (~kind.is_out),
      .b_after   (b_after),
      .hl_after  (hl_after)
   );

   always_comb begin
      io_req    = (state == ST_IO);
      io_we     = kind.is_out;
      io_addr   = addr_w;
      io_wdata  = kind.is_block ? data_q : acc_q;
      mem_req   = (state == ST_MEM);
      mem_we    = ~kind.is_out;
      mem_addr  = hl_q;
      mem_wdata = data_q;
      busy      = (state != ST_IDLE);
      done      = (state == ST_FIN);
      zero      = (b_q == '0);
      acc_out   = acc_q;
      b_out     = b_q;
      hl_out    = hl_q;
   end

endmodule

// File: rtl/blkio_checker.sv
module blkio_checker #(
   parameter int DATA_W = 8,
   parameter int HL_W   = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                io_req,
   input logic                io_we,
   input logic                io_rdy,
   input logic [2*DATA_W-1:0] io_addr,
   input logic [DATA_W-1:0]   io_wdata,
   input logic                mem_req,
   input logic                mem_we,
   input logic                mem_rdy,
   input logic [HL_W-1:0]     mem_addr,
   input logic                busy,
   input logic                done,
   input logic                zero,
   input logic [DATA_W-1:0]   b_out
);

   a_r9_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_req && mem_req));

   a_r9_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
      io_req && !io_rdy |=> io_req && $stable(io_addr) && $stable(io_we) && $stable(io_wdata));

   a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (zero == (b_out == '0)));

   a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req || mem_req) |-> busy && !done);

endmodule

bind blkio_sequencer blkio_checker #(.DATA_W(DATA_W), .HL_W(HL_W)) u_blkio_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_req   (io_req),
   .io_we    (io_we),
   .io_rdy   (io_rdy),
   .io_addr  (io_addr),
   .io_wdata (io_wdata),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_rdy  (mem_rdy),
   .mem_addr (mem_addr),
   .busy     (busy),
   .done     (done),
   .zero     (zero),
   .b_out    (b_out)
);

// File: tb/test_blkio_sequencer.sv
module test_blkio_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  cmd = '0;
   logic        compat = 1'b0;
   logic [7:0]  acc_in = '0, b_in = '0, c_in = '0, port_in = '0;
   logic [15:0] hl_in = '0;
   logic        io_req, io_we, mem_req, mem_we, busy, done, zero;
   logic [15:0] io_addr, mem_addr, hl_out;
   logic [7:0]  io_wdata, mem_wdata, acc_out, b_out;
   logic [7:0]  io_rdata = '0, mem_rdata = '0;
   logic        io_rdy = 1'b0, mem_rdy = 1'b0;

   always #4 clk = ~clk;

   blkio_sequencer i_blkio_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .compat(compat),
      .acc_in(acc_in), .b_in(b_in), .c_in(c_in), .port_in(port_in), .hl_in(hl_in),
      .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_rdy(io_rdy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
      .busy(busy), .done(done), .zero(zero),
      .acc_out(acc_out), .b_out(b_out), .hl_out(hl_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] mem_model [0:65535];

   // access log: kind 0 port read, 1 port write, 2 mem read, 3 mem write
   int         log_n = 0;
   logic [1:0] log_k [0:599];
   logic [15:0] log_a [0:599];
   logic [7:0] log_d [0:599];
   int         exp_n = 0;
   logic [1:0] exp_k [0:599];
   logic [15:0] exp_a [0:599];
   logic [7:0] exp_d [0:599];
   logic [7:0] exp_b, exp_acc;
   logic [15:0] exp_hl;
   bit         both_req = 1'b0;

   function automatic logic [7:0] io_val(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h96;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // bus models: decide ready at the falling edge, record completed accesses
   always @(negedge clk) begin
      io_rdy  = 1'b0;
      mem_rdy = 1'b0;
      if (rst_n && io_req && mem_req) both_req = 1'b1;
      if (rst_n && io_req && ($urandom % 3 != 0)) begin
         io_rdy = 1'b1;
         if (log_n < 600) begin
            log_k[log_n] = io_we ? 2'd1 : 2'd0;
            log_a[log_n] = io_addr;
            if (io_we) log_d[log_n] = io_wdata;
            else begin
               io_rdata = io_val(io_addr);
               log_d[log_n] = io_rdata;
            end
            log_n++;
         end
      end
      if (rst_n && mem_req && ($urandom % 3 != 0)) begin
         mem_rdy = 1'b1;
         if (log_n < 600) begin
            log_k[log_n] = mem_we ? 2'd3 : 2'd2;
            log_a[log_n] = mem_addr;
            if (mem_we) begin
               mem_model[mem_addr] = mem_wdata;
               log_d[log_n] = mem_wdata;
            end else begin
               mem_rdata = mem_model[mem_addr];
               log_d[log_n] = mem_rdata;
            end
            log_n++;
         end
      end
   end

   task automatic push(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
      exp_k[exp_n] = k; exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
   endtask

   task automatic build_exp(input logic [3:0] code, input logic cp, input logic [7:0] a0,
                            input logic [7:0] b0, input logic [7:0] c0, input logic [7:0] p0,
                            input logic [15:0] h0);
      logic [7:0] b = b0, acc = a0, d;
      logic [15:0] hl = h0, ad;
      exp_n = 0;
      if (code < 4) begin
         ad = (code < 2) ? {(cp ? p0 : a0), p0} : {b0, c0};
         if (code[0] == 1'b0) begin
            d = io_val(ad); push(2'd0, ad, d); acc = d;
         end else push(2'd1, ad, acc);
      end else if (code < 12) begin
         do begin
            if (code[1] == 1'b0) begin
               ad = {b, c0}; d = io_val(ad);
               push(2'd0, ad, d); push(2'd3, hl, d); b = b - 8'd1;
            end else begin
               b = b - 8'd1; d = mem_model[hl];
               push(2'd2, hl, d); push(2'd1, {b, c0}, d);
            end
            hl = code[0] ? hl - 16'd1 : hl + 16'd1;
         end while (code >= 8 && b != 8'd0);
      end
      exp_b = b; exp_acc = acc; exp_hl = hl;
   endtask

   task automatic run_op(input logic [3:0] code, input logic cp, input logic [7:0] a0,
                         input logic [7:0] b0, input logic [7:0] c0, input logic [7:0] p0,
                         input logic [15:0] h0, input string seq_req);
      string breq;
      int cyc = 0;
      int bad = -1;
      build_exp(code, cp, a0, b0, c0, p0, h0);
      log_n = 0;
      both_req = 1'b0;
      @(negedge clk);
      cmd = code; compat = cp; acc_in = a0; b_in = b0; c_in = c0; port_in = p0; hl_in = h0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 6000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done, "R10", "done seen", {31'd0, done}, 32'd1);
      for (int i = 0; i < exp_n; i++)
         if (bad < 0 && (i >= log_n || log_k[i] != exp_k[i] || log_a[i] != exp_a[i] || log_d[i] != exp_d[i]))
            bad = i;
      if (bad < 0 && log_n != exp_n) bad = exp_n;
      chk(bad < 0, seq_req, "access sequence (count/first mismatch index)",
          32'(log_n), 32'(exp_n));
      if (bad >= 0 && bad < exp_n && bad < log_n)
         $display("  mismatch at %0d: got k%0d a%0h d%0h, want k%0d a%0h d%0h", bad,
                  log_k[bad], log_a[bad], log_d[bad], exp_k[bad], exp_a[bad], exp_d[bad]);
      breq = (code >= 8 && code < 12) ? "R8" : (code >= 4 && code < 12) ? "R7" :
             (code >= 12) ? "R11" : "R3";
      chk(b_out == exp_b, breq, "b_out", 32'(b_out), 32'(exp_b));
      chk(hl_out == exp_hl, (code >= 12) ? "R11" : "R6", "hl_out", 32'(hl_out), 32'(exp_hl));
      chk(acc_out == exp_acc, (code >= 12) ? "R11" : "R1", "acc_out", 32'(acc_out), 32'(exp_acc));
      chk(zero == (exp_b == 8'd0), "R10", "zero", {31'd0, zero}, {31'd0, exp_b == 8'd0});
      chk(!both_req, "R9", "port and memory requests overlapped", {31'd0, both_req}, 32'd0);
      @(negedge clk);
      chk(!done && !busy, "R10", "done/busy after pulse", {30'd0, done, busy}, 32'd0);
   endtask

   function automatic string seq_tag(input logic [3:0] code, input logic cp);
      if (code < 2) return cp ? "R2" : "R1";
      if (code < 4) return "R3";
      if (code < 12) return code[1] ? "R5" : "R4";
      return "R11";
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 65536; i++) mem_model[i] = 8'(i) ^ 8'(i >> 8) ^ 8'hC3;
      repeat (3) @(negedge clk);
      // reset state
      chk(!busy && !done && !io_req && !mem_req, "R10", "reset outputs",
          {28'd0, busy, done, io_req, mem_req}, 32'd0);
      chk(b_out == 8'd0 && hl_out == 16'd0, "R10", "reset registers",
          {8'd0, b_out, hl_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corner cases
      run_op(4'd0, 1'b0, 8'hA5, 8'h11, 8'h22, 8'h3C, 16'h1000, "R1");
      run_op(4'd1, 1'b0, 8'h5A, 8'h11, 8'h22, 8'h3C, 16'h1000, "R1");
      run_op(4'd0, 1'b1, 8'hA5, 8'h11, 8'h22, 8'h3C, 16'h1000, "R2");
      run_op(4'd1, 1'b1, 8'h5A, 8'h11, 8'h22, 8'h7E, 16'h1000, "R2");
      run_op(4'd2, 1'b0, 8'h01, 8'hFE, 8'h0A, 8'h00, 16'h2000, "R3");
      run_op(4'd3, 1'b0, 8'h77, 8'hFE, 8'h0A, 8'h00, 16'h2000, "R3");
      run_op(4'd4, 1'b0, 8'h00, 8'h05, 8'h40, 8'h00, 16'hFFFF, "R4"); // R6 wrap up
      run_op(4'd7, 1'b0, 8'h00, 8'h05, 8'h41, 8'h00, 16'h0000, "R5"); // R6 wrap down
      run_op(4'd8, 1'b0, 8'h00, 8'h00, 8'h42, 8'h00, 16'h3000, "R4"); // R8 256 bytes
      run_op(4'd11, 1'b0, 8'h00, 8'h00, 8'h43, 8'h00, 16'h0080, "R5"); // R8 256 bytes
      run_op(4'd9, 1'b0, 8'h00, 8'h01, 8'h44, 8'h00, 16'h4000, "R4");
      run_op(4'd10, 1'b0, 8'h00, 8'h01, 8'h45, 8'h00, 16'h4000, "R5");
      run_op(4'd10, 1'b0, 8'h00, 8'h03, 8'h46, 8'h00, 16'hFFFE, "R5");
      run_op(4'd13, 1'b1, 8'h12, 8'h34, 8'h56, 8'h78, 16'h9ABC, "R11");
      // random mix
      for (int n = 0; n < 40; n++) begin
         logic [3:0] rc = 4'($urandom % 16);
         logic rcp = 1'($urandom);
         run_op(rc, rcp, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                16'($urandom), seq_tag(rc, rcp));
      end
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule